// File: doc/BRIEF.md
# Line Loss-of-Signal Alarm Detector

This block watches the recovered receive data of a digital line interface. Each bit period delivers one bit, marked by a strobe. When a programmable number T of strobed bits in a row are all zero, the block raises a loss-of-signal (red alarm) status. After that, the status clears only when at least M ones land inside one recovery window of T bit periods. M is programmable too.

The recovery window counter runs freely on the strobe from reset. It wraps every T strobes. At each wrap it loads new values of T and M from the programming inputs, and it resets the count of ones. An alarm-simulation input forces the status active. A rising edge of the status sets a sticky interrupt flag. Software clears that flag by writing one. An interrupt request is the flag gated by a mask-enable input.

Valid T lies strictly between 16 and 4096. M is expected to be at least 1.

Top module: `los_alarm_detector`

## Requirements
- R1: After a synchronous active-low reset, `los_status`, `irq_flag` and `irq_req` are all 0, provided `sim_en` is 0.
- R2: `los_status` goes to 1 right after the clock edge that samples the T-th consecutive strobed zero. After T-1 zeros it is still 0.
- R3: A strobed one received before T zeros restarts the zero run from zero.
- R4: Once the alarm is raised, any further run of zeros keeps it raised. The zero-run counter saturates and never wraps back.
- R5: While the alarm is raised, it clears on the strobe that brings the ones count of the current window up to M.
- R6: The ones count restarts at every window start. Ones spread so that no window holds M of them do not clear the alarm.
- R7: If M is greater than T, the alarm never clears, however many ones arrive.
- R8: Clock cycles with `bit_en` low leave the zero run, the window position and the alarm unchanged.
- R9: A rising edge of `los_status` sets `irq_flag` one clock later. The flag then stays 1 until a cycle with `irq_clr` high clears it.
- R10: When a rising edge of `los_status` and `irq_clr` fall in the same cycle, the flag is set, not cleared.
- R11: `irq_req` is 1 exactly when `irq_flag` is 1 and `irq_mask_en` is 1.
- R12: `sim_en` high forces `los_status` to 1. When it drops and no real loss exists, `los_status` returns to 0.
- R13: `win_len` and `ones_req` are taken only at reset and at each window wrap. The wrap happens every T strobes, counted from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-period strobe; state advances only when high |
| rx_bit | input | 1 | Received data bit |
| win_len | input | CNT_W | Programmed T: zero-run length and window length |
| ones_req | input | CNT_W | Programmed M: ones needed inside one window to recover |
| sim_en | input | 1 | Alarm simulation: forces the status active |
| irq_clr | input | 1 | Write-one clear of the interrupt flag |
| irq_mask_en | input | 1 | Interrupt enable |
| los_status | output | 1 | Live loss-of-signal status |
| irq_flag | output | 1 | Sticky interrupt status |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default counter width of 12 bits. It programs T at 20 and then 30, so that zero runs, window wraps and saturation all fall within a few hundred strobes. It uses M = 3 for recovery. It then switches to M = 40 with T = 30, which reaches the case where recovery can never happen. Changing T in the middle of a run shows that the new value takes effect only after the next window wrap. The bench also inserts stretches with the strobe held low, to show that those cycles leave the state unchanged.

// File: rtl/los_pkg.sv
// Package: shared types for the loss-of-signal detector.
// Assumes: nothing beyond IEEE 1800-2017.
package los_pkg;

    // Link condition as seen by the recovery logic
    typedef enum logic {
        LINK_UP   = 1'b0,
        LINK_DOWN = 1'b1
    } link_state_e;

endpackage

// File: rtl/los_cfg_window.sv
// Module: los_cfg_window
// Free-running window position counter, advanced by the bit strobe.
// It wraps every T strobes and holds the working copies of T and M.
// The working copies load at reset and on each window wrap.
// Assumes: win_len lies between 17 and 4095.
module los_cfg_window #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [CNT_W-1:0] win_len,
    input  logic [CNT_W-1:0] ones_req,
    output logic [CNT_W-1:0] t_cfg,
    output logic [CNT_W-1:0] m_cfg,
    output logic             win_start,
    output logic             win_last
);

    logic [CNT_W-1:0] wpos;
    logic [CNT_W-1:0] t_last;

    // Position of the final bit of a window
    always_comb begin
        t_last    = t_cfg - CNT_W'(1);
        win_last  = (wpos >= t_last);
        win_start = (wpos == '0);
    end

    // Advance the window position and reload the configuration at the wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wpos  <= '0;
            t_cfg <= win_len;
            m_cfg <= ones_req;
        end else if (bit_en) begin
            if (win_last) begin
                wpos  <= '0;
                t_cfg <= win_len;
                m_cfg <= ones_req;
            end else begin
                wpos <= wpos + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/los_zero_run.sv
// Module: los_zero_run
// Counts consecutive strobed zeros. The counter saturates at T.
// It flags the strobe on which the run reaches T.
// Assumes: t_cfg is nonzero.
module los_zero_run #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic [CNT_W-1:0] t_cfg,
    output logic [CNT_W-1:0] zrun,
    output logic             loss_hit
);

    logic [CNT_W-1:0] zrun_next;

    // Next run length: restart on a one, hold once the run reaches T
    always_comb begin
        if (rx_bit)
            zrun_next = '0;
        else if (zrun >= t_cfg)
            zrun_next = zrun;
        else
            zrun_next = zrun + CNT_W'(1);
        loss_hit = bit_en && (zrun_next >= t_cfg);
    end

    // Store the run length on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            zrun <= '0;
        else if (bit_en)
            zrun <= zrun_next;
    end

endmodule

// File: rtl/los_recovery.sv
// Module: los_recovery
// Holds the real loss state. It counts ones per window while the loss
// persists, and it declares recovery once M ones are seen in one window.
// Assumes: m_cfg >= 1. The count never exceeds T, so it fits CNT_W bits.
module los_recovery
    import los_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic             loss_hit,
    input  logic             win_start,
    input  logic [CNT_W-1:0] m_cfg,
    output logic             link_lost
);

    link_state_e      state;
    logic [CNT_W-1:0] ones_cnt;
    logic [CNT_W-1:0] ones_sum;
    logic             ones_met;

    // Ones seen in the current window, this bit included
    always_comb begin
        ones_sum  = (win_start ? '0 : ones_cnt) + CNT_W'(rx_bit);
        ones_met  = (ones_sum >= m_cfg);
        link_lost = (state == LINK_DOWN);
    end

    // Loss state and ones count, updated on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LINK_UP;
            ones_cnt <= '0;
        end else if (bit_en) begin
            case (state)
                LINK_UP: begin
                    ones_cnt <= '0;
                    if (loss_hit)
                        state <= LINK_DOWN;
                end
                default: begin
                    if (ones_met) begin
                        state    <= LINK_UP;
                        ones_cnt <= '0;
                    end else begin
                        ones_cnt <= ones_sum;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/los_irq_ctrl.sv
// Module: los_irq_ctrl
// Detects rising edges of the status and keeps the sticky interrupt flag.
// A rising edge wins over a clear in the same cycle. Runs every clock.
// Assumes: status is a registered-level signal from the same clock domain.
module los_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic status,
    input  logic irq_clr,
    input  logic irq_mask_en,
    output logic irq_flag,
    output logic irq_req
);

    logic status_d;
    logic status_rise;

    // Edge detect and request gating
    always_comb begin
        status_rise = status && !status_d;
        irq_req     = irq_flag && irq_mask_en;
    end

    // Delayed status and sticky flag with priority to a new edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_d <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            status_d <= status;
            if (status_rise)
                irq_flag <= 1'b1;
            else if (irq_clr)
                irq_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/los_alarm_detector.sv
// Module: los_alarm_detector (top)
// Loss-of-signal alarm for a digital line. T consecutive zeros raise the alarm.
// M ones within one T-bit window clear it. Simulation forces the status on.
// Assumes: 16 < T < 4096 and M >= 1. Inputs are synchronous to clk.
module los_alarm_detector #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic [CNT_W-1:0] win_len,
    input  logic [CNT_W-1:0] ones_req,
    input  logic             sim_en,
    input  logic             irq_clr,
    input  logic             irq_mask_en,
    output logic             los_status,
    output logic             irq_flag,
    output logic             irq_req
);

    logic [CNT_W-1:0] t_cfg;
    logic [CNT_W-1:0] m_cfg;
    logic [CNT_W-1:0] zrun;
    logic             win_start;
    logic             win_last;
    logic             loss_hit;
    logic             link_lost;

    los_cfg_window #(.CNT_W(CNT_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .win_len   (win_len),
        .ones_req  (ones_req),
        .t_cfg     (t_cfg),
        .m_cfg     (m_cfg),
        .win_start (win_start),
        .win_last  (win_last)
    );

    los_zero_run #(.CNT_W(CNT_W)) u_zero (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rx_bit   (rx_bit),
        .t_cfg    (t_cfg),
        .zrun     (zrun),
        .loss_hit (loss_hit)
    );

    los_recovery #(.CNT_W(CNT_W)) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .rx_bit    (rx_bit),
        .loss_hit  (loss_hit),
        .win_start (win_start),
        .m_cfg     (m_cfg),
        .link_lost (link_lost)
    );

    // Live status: real loss or simulated alarm
    always_comb los_status = link_lost || sim_en;

    los_irq_ctrl u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .status      (los_status),
        .irq_clr     (irq_clr),
        .irq_mask_en (irq_mask_en),
        .irq_flag    (irq_flag),
        .irq_req     (irq_req)
    );

endmodule

// File: rtl/los_alarm_detector_chk.sv
// Module: los_alarm_detector_chk
// Assertion checker, bound into every los_alarm_detector instance.
// Assumes: M >= 1, so a recovery always happens on a strobed one.
module los_alarm_detector_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             rx_bit,
    input logic             irq_clr,
    input logic             irq_mask_en,
    input logic             los_status,
    input logic             irq_flag,
    input logic             irq_req,
    input logic             link_lost,
    input logic [CNT_W-1:0] zrun
);

    // R2: a real loss is raised only on a strobed zero
    a_r2_set_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_lost) |-> $past(bit_en && !rx_bit));

    // R3: a strobed one leaves the zero run empty
    a_r3_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bit_en && rx_bit) |-> (zrun == '0));

    // R5: recovery happens only on a strobed one
    a_r5_clear_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_lost) |-> $past(bit_en && rx_bit));

    // R8: no strobe, no change of loss state or zero run
    a_r8_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(link_lost) && $stable(zrun)));

    // R9: a status rise sets the flag in the next cycle
    a_r9_rise_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_status) |=> irq_flag);

    // R9: without a clear, the flag stays set
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R11: a request needs the enable
    a_r11_req_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_mask_en);

endmodule

bind los_alarm_detector los_alarm_detector_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .rx_bit      (rx_bit),
    .irq_clr     (irq_clr),
    .irq_mask_en (irq_mask_en),
    .los_status  (los_status),
    .irq_flag    (irq_flag),
    .irq_req     (irq_req),
    .link_lost   (link_lost),
    .zrun        (zrun)
);

// File: tb/los_alarm_detector_test.sv
// Bench: a behavioural reference model, compared on every clock,
// plus directed checks at the points the requirements name.
module los_alarm_detector_test;

    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_en = 1'b0;
    logic             rx_bit = 1'b0;
    logic [CNT_W-1:0] win_len = 12'd20;
    logic [CNT_W-1:0] ones_req = 12'd3;
    logic             sim_en = 1'b0;
    logic             irq_clr = 1'b0;
    logic             irq_mask_en = 1'b0;
    logic             los_status;
    logic             irq_flag;
    logic             irq_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 1'b0;
    string cur_req = "R1";

    // Reference state
    int m_zr, m_wp, m_oc, m_tc, m_mc;
    bit m_lost, m_sd, m_fl;

    always #5 clk = ~clk;

    los_alarm_detector #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .win_len(win_len), .ones_req(ones_req), .sim_en(sim_en),
        .irq_clr(irq_clr), .irq_mask_en(irq_mask_en),
        .los_status(los_status), .irq_flag(irq_flag), .irq_req(irq_req)
    );

    // Reference model, advanced at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_zr = 0; m_wp = 0; m_oc = 0; m_lost = 0; m_sd = 0; m_fl = 0;
            m_tc = int'(win_len); m_mc = int'(ones_req);
            started = 1'b1;
        end else begin
            bit st;
            st = m_lost | sim_en;
            if (st && !m_sd) m_fl = 1;
            else if (irq_clr) m_fl = 0;
            m_sd = st;
            if (bit_en) begin
                int zn;
                int c;
                zn = rx_bit ? 0 : ((m_zr >= m_tc) ? m_zr : m_zr + 1);
                if (!m_lost) begin
                    if (zn >= m_tc) m_lost = 1;
                    m_oc = 0;
                end else begin
                    c = ((m_wp == 0) ? 0 : m_oc) + int'(rx_bit);
                    if (c >= m_mc) begin m_lost = 0; m_oc = 0; end
                    else m_oc = c;
                end
                m_zr = zn;
                if (m_wp >= m_tc - 1) begin
                    m_wp = 0; m_tc = int'(win_len); m_mc = int'(ones_req);
                end else m_wp = m_wp + 1;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the edge
    always @(negedge clk) begin
        if (started && rst_n) begin
            chk(cur_req, "los_status", int'(los_status), int'(m_lost | sim_en));
            chk(cur_req, "irq_flag", int'(irq_flag), int'(m_fl));
            chk(cur_req, "irq_req", int'(irq_req), int'(m_fl & irq_mask_en));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic send(bit b, int n);
        for (int i = 0; i < n; i++) begin
            bit_en = 1'b1;
            rx_bit = b;
            tick();
        end
        bit_en = 1'b0;
    endtask

    task automatic idle(int n);
        bit_en = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        #0;
        // R1: reset state
        cur_req = "R1";
        chk("R1", "status", int'(los_status), 0);
        chk("R1", "flag", int'(irq_flag), 0);
        chk("R1", "req", int'(irq_req), 0);

        // R3: a one breaks the zero run
        cur_req = "R3";
        send(1'b0, 19); send(1'b1, 1); send(1'b0, 19);
        chk("R3", "status after broken runs", int'(los_status), 0);

        // R8: no strobe, no progress
        cur_req = "R8";
        rx_bit = 1'b0;
        idle(30);
        chk("R8", "status after idle zeros", int'(los_status), 0);

        // R2: the twentieth zero raises the alarm
        cur_req = "R2";
        send(1'b0, 1);
        chk("R2", "status on T-th zero", int'(los_status), 1);
        chk("R9", "flag not yet set", int'(irq_flag), 0);
        cur_req = "R9";
        tick();
        chk("R9", "flag one clock later", int'(irq_flag), 1);
        chk("R11", "req masked", int'(irq_req), 0);
        cur_req = "R11";
        irq_mask_en = 1'b1;
        #1;
        chk("R11", "req enabled", int'(irq_req), 1);

        // R4: long loss, no wrap
        cur_req = "R4";
        send(1'b0, 70);
        chk("R4", "status after long loss", int'(los_status), 1);

        // R6: too few ones per window
        cur_req = "R6";
        for (int k = 0; k < 6; k++) begin
            send(1'b1, 1); send(1'b0, 9);
        end
        chk("R6", "status with sparse ones", int'(los_status), 1);

        // R9: write-one clear
        cur_req = "R9";
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        chk("R9", "flag cleared", int'(irq_flag), 0);
        tick();
        chk("R9", "flag stays clear", int'(irq_flag), 0);

        // R5: recovery with enough ones
        cur_req = "R5";
        send(1'b1, 5);
        chk("R5", "status recovered", int'(los_status), 0);

        // R10 and R12: simulated alarm with a clear in the same cycle
        cur_req = "R10";
        sim_en = 1'b1; irq_clr = 1'b1;
        #1;
        chk("R12", "status forced", int'(los_status), 1);
        tick();
        irq_clr = 1'b0;
        chk("R10", "rise beats clear", int'(irq_flag), 1);
        cur_req = "R12";
        send(1'b1, 3);
        sim_en = 1'b0;
        #1;
        chk("R12", "status after release", int'(los_status), 0);
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;

        // R13: new T and M take effect at the window wrap
        cur_req = "R13";
        win_len = 12'd30; ones_req = 12'd40;
        send(1'b1, 40);
        send(1'b0, 29);
        chk("R13", "status after 29 zeros with T=30", int'(los_status), 0);
        send(1'b0, 1);
        chk("R13", "status after 30 zeros", int'(los_status), 1);

        // R7: M above T never recovers
        cur_req = "R7";
        send(1'b1, 200);
        chk("R7", "status with M>T", int'(los_status), 1);

        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule